// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit executes the bit-manipulation operations of a 32-bit RISC-V integer pipeline. The supported set covers the basic group, the single-bit group and the shifted-add group. The issuing stage presents two register operands, a 5-bit immediate and an already decoded operation select, and raises `start` for one cycle. The unit answers with a one-cycle `done` pulse. The 32-bit `result` stays on the port until the next accepted operation.

Most operations are computed in a single combinational stage and registered, so `done` follows `start` by one cycle. The three counting operations (leading zeros, trailing zeros, population) walk the operand one bit per cycle. They finish in a fixed 32 cycles, and `busy` stays high during that walk. While the unit is busy, a new `start` is dropped.

Top module: `bitmanip_unit`

## Requirements
- R1: Logic operations on rs1 and rs2: opSel 0 gives rs1 & ~rs2, opSel 1 gives rs1 | ~rs2, and opSel 2 gives ~(rs1 ^ rs2).
- R2: Counting on rs1: opSel 3 counts leading zeros, opSel 4 counts trailing zeros and opSel 5 counts set bits. Every count lies in 0..32, and an all-zero rs1 gives 32 for both zero counts. `done` comes at most 33 cycles after `start`.
- R3: Width conversion of rs1: opSel 6 sign-extends bits 7:0, opSel 7 sign-extends bits 15:0, and opSel 8 zero-extends bits 15:0 with the upper half cleared.
- R4: Min and max of rs1 and rs2: opSel 9 is the signed minimum, 10 the unsigned minimum, 11 the signed maximum and 12 the unsigned maximum.
- R5: Rotates of rs1: opSel 13 rotates left by rs2, opSel 14 rotates right by rs2, and opSel 15 rotates right by imm. Only the low 5 bits of the amount count.
- R6: opSel 16 reverses the byte order of rs1. In opSel 17, each byte of the result is 0xFF when the matching byte of rs1 has any bit set, and 0x00 when it has none.
- R7: Single-bit operations on rs1, with the index taken from rs2[4:0] or from imm. opSel 18/22 set the bit, 19/23 clear it, 20/24 invert it, and 21/25 return it in bit 0 with all other bits zero. The lower code of each pair uses rs2, the higher code uses imm.
- R8: opSel 26, 27 and 28 return (rs1 << n) + rs2 modulo 2^32, with n = 1, 2 and 3.
- R9: opSel 29, 30 and 31 are illegal. They give a result of zero and raise `illegal` in the same cycle as `done`. `illegal` is low whenever `done` is low.
- R10: For every operation other than the counts, `done` rises in the cycle after the cycle in which `start` is sampled. `done` is high for exactly one cycle. `result` changes only in a cycle in which `done` is high.
- R11: For the counting operations, `busy` is high from the cycle after `start` up to the cycle before `done`. A `start` while `busy` is high is ignored: it yields no extra `done`, and the pending result is not changed.
- R12: After reset, `done`, `busy` and `illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches the operation on the inputs |
| opSel | input | 5 | Operation code |
| rs1 | input | 32 | First operand |
| rs2 | input | 32 | Second operand or bit/rotate amount |
| imm | input | 5 | Immediate amount or bit index |
| busy | output | 1 | Count operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Operation code was not supported |
| result | output | 32 | Result, held until the next operation |

## Verification
The bench targets the counting edges. It applies zero, all ones, a single low bit and a single high bit. A scan with an off-by-one fault would return 31 or 33 where 32 is due, or would stop on the wrong side of the first set bit. Rotates and bit indices are driven with amounts whose upper bits are set, which catches a design that uses the full amount instead of only its low 5 bits. Signed min/max is checked across the sign boundary, where an unsigned compare gives the wrong pick. The bench also issues a start while a count is running; a unit that took it would overwrite the pending count or pulse `done` twice.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;

  typedef enum logic [4:0] {
    OP_ANDN   = 5'd0,
    OP_ORN    = 5'd1,
    OP_XNOR   = 5'd2,
    OP_CLZ    = 5'd3,
    OP_CTZ    = 5'd4,
    OP_CPOP   = 5'd5,
    OP_SEXTB  = 5'd6,
    OP_SEXTH  = 5'd7,
    OP_ZEXTH  = 5'd8,
    OP_MIN    = 5'd9,
    OP_MINU   = 5'd10,
    OP_MAX    = 5'd11,
    OP_MAXU   = 5'd12,
    OP_ROL    = 5'd13,
    OP_ROR    = 5'd14,
    OP_RORI   = 5'd15,
    OP_REV8   = 5'd16,
    OP_ORCB   = 5'd17,
    OP_BSET   = 5'd18,
    OP_BCLR   = 5'd19,
    OP_BINV   = 5'd20,
    OP_BEXT   = 5'd21,
    OP_BSETI  = 5'd22,
    OP_BCLRI  = 5'd23,
    OP_BINVI  = 5'd24,
    OP_BEXTI  = 5'd25,
    OP_SH1ADD = 5'd26,
    OP_SH2ADD = 5'd27,
    OP_SH3ADD = 5'd28
  } bmOp_e;

  typedef enum logic [1:0] {
    CNT_LEAD  = 2'd0,
    CNT_TRAIL = 2'd1,
    CNT_POP   = 2'd2
  } cntKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOne;   // capture single-cycle result
    logic loadIter;  // capture operand, clear count state
    logic stepIter;  // examine one bit
    logic lastStep;  // final bit, write count to result
  } bmStrobe_t;

endpackage

// File: rtl/bitmanip_ctrl.sv
module bitmanip_ctrl
  import bitmanip_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  bmOp_e           opSel,
  output bmStrobe_t       strobe,
  output logic [IW-1:0]   stepIdx,
  output logic            busy,
  output logic            done,
  output logic            illegal
);

  logic          runQ;
  logic [IW-1:0] cntQ;
  logic          doneQ;
  logic          illegalQ;
  logic          accept;
  logic          isCount;
  logic          isIllegal;

  always_comb begin
    accept    = start && !runQ;
    isCount   = (opSel == OP_CLZ) || (opSel == OP_CTZ) || (opSel == OP_CPOP);
    isIllegal = opSel > OP_SH3ADD;
    strobe.loadOne  = accept && !isCount;
    strobe.loadIter = accept && isCount;
    strobe.stepIter = runQ;
    strobe.lastStep = runQ && (cntQ == IW'(XLEN - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      cntQ     <= '0;
      doneQ    <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      doneQ    <= strobe.loadOne || strobe.lastStep;
      illegalQ <= strobe.loadOne && isIllegal;
      if (strobe.loadIter) begin
        runQ <= 1'b1;
        cntQ <= '0;
      end else if (strobe.lastStep) begin
        runQ <= 1'b0;
        cntQ <= '0;
      end else if (runQ) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign stepIdx = cntQ;
  assign busy    = runQ;
  assign done    = doneQ;
  assign illegal = illegalQ;

endmodule

// File: rtl/bitmanip_dp.sv
module bitmanip_dp
  import bitmanip_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IW = $clog2(XLEN),
  localparam int NB = XLEN / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  bmStrobe_t       strobe,
  input  logic [IW-1:0]   stepIdx,
  input  bmOp_e           opSel,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic [4:0]      imm,
  output logic [XLEN-1:0] result
);

  logic [XLEN-1:0] resultQ;
  logic [XLEN-1:0] opndQ;
  cntKind_e        kindQ;
  logic [IW:0]     accQ;
  logic [IW:0]     accNext;
  logic            seenQ;
  logic            curBit;
  logic [XLEN-1:0] oneResult;
  logic [XLEN-1:0] revBytes;
  logic [XLEN-1:0] orcBytes;
  logic [IW-1:0]   regAmt;
  logic [IW-1:0]   immAmt;

  assign regAmt = rs2[IW-1:0];
  assign immAmt = imm[IW-1:0];

  function automatic logic [XLEN-1:0] rotLeft(input logic [XLEN-1:0] a, input logic [IW-1:0] s);
    if (s == '0) return a;
    return (a << s) | (a >> (XLEN - int'(s)));
  endfunction

  function automatic logic [XLEN-1:0] rotRight(input logic [XLEN-1:0] a, input logic [IW-1:0] s);
    if (s == '0) return a;
    return (a >> s) | (a << (XLEN - int'(s)));
  endfunction

  function automatic logic [XLEN-1:0] bitMask(input logic [IW-1:0] s);
    return {{(XLEN-1){1'b0}}, 1'b1} << s;
  endfunction

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bytes
      assign revBytes[8*b +: 8] = rs1[8*(NB-1-b) +: 8];
      assign orcBytes[8*b +: 8] = {8{|rs1[8*b +: 8]}};
    end
  endgenerate

  always_comb begin
    case (opSel)
      OP_ANDN:   oneResult = rs1 & ~rs2;
      OP_ORN:    oneResult = rs1 | ~rs2;
      OP_XNOR:   oneResult = ~(rs1 ^ rs2);
      OP_SEXTB:  oneResult = {{(XLEN-8){rs1[7]}}, rs1[7:0]};
      OP_SEXTH:  oneResult = {{(XLEN-16){rs1[15]}}, rs1[15:0]};
      OP_ZEXTH:  oneResult = {{(XLEN-16){1'b0}}, rs1[15:0]};
      OP_MIN:    oneResult = ($signed(rs1) < $signed(rs2)) ? rs1 : rs2;
      OP_MINU:   oneResult = (rs1 < rs2) ? rs1 : rs2;
      OP_MAX:    oneResult = ($signed(rs1) < $signed(rs2)) ? rs2 : rs1;
      OP_MAXU:   oneResult = (rs1 < rs2) ? rs2 : rs1;
      OP_ROL:    oneResult = rotLeft(rs1, regAmt);
      OP_ROR:    oneResult = rotRight(rs1, regAmt);
      OP_RORI:   oneResult = rotRight(rs1, immAmt);
      OP_REV8:   oneResult = revBytes;
      OP_ORCB:   oneResult = orcBytes;
      OP_BSET:   oneResult = rs1 | bitMask(regAmt);
      OP_BCLR:   oneResult = rs1 & ~bitMask(regAmt);
      OP_BINV:   oneResult = rs1 ^ bitMask(regAmt);
      OP_BEXT:   oneResult = {{(XLEN-1){1'b0}}, |(rs1 & bitMask(regAmt))};
      OP_BSETI:  oneResult = rs1 | bitMask(immAmt);
      OP_BCLRI:  oneResult = rs1 & ~bitMask(immAmt);
      OP_BINVI:  oneResult = rs1 ^ bitMask(immAmt);
      OP_BEXTI:  oneResult = {{(XLEN-1){1'b0}}, |(rs1 & bitMask(immAmt))};
      OP_SH1ADD: oneResult = (rs1 << 1) + rs2;
      OP_SH2ADD: oneResult = (rs1 << 2) + rs2;
      OP_SH3ADD: oneResult = (rs1 << 3) + rs2;
      default:   oneResult = '0;
    endcase
  end

  // one bit per step: from the top for leading, from the bottom otherwise
  always_comb begin
    if (kindQ == CNT_LEAD) curBit = opndQ[(XLEN-1) - int'(stepIdx)];
    else                   curBit = opndQ[stepIdx];
    if (kindQ == CNT_POP)  accNext = accQ + (IW+1)'(curBit);
    else if (!seenQ && !curBit) accNext = accQ + 1'b1;
    else                   accNext = accQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      opndQ   <= '0;
      kindQ   <= CNT_LEAD;
      accQ    <= '0;
      seenQ   <= 1'b0;
    end else begin
      if (strobe.loadOne) resultQ <= oneResult;
      if (strobe.loadIter) begin
        opndQ <= rs1;
        accQ  <= '0;
        seenQ <= 1'b0;
        case (opSel)
          OP_CLZ:  kindQ <= CNT_LEAD;
          OP_CTZ:  kindQ <= CNT_TRAIL;
          default: kindQ <= CNT_POP;
        endcase
      end else if (strobe.stepIter) begin
        accQ  <= accNext;
        seenQ <= seenQ | curBit;
        if (strobe.lastStep) resultQ <= {{(XLEN-IW-1){1'b0}}, accNext};
      end
    end
  end

  assign result = resultQ;

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bitmanip_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [4:0]      opSel,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic [4:0]      imm,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] result
);

  bmOp_e         opCode;
  bmStrobe_t     strobe;
  logic [IW-1:0] stepIdx;

  assign opCode = bmOp_e'(opSel);

  bitmanip_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opSel   (opCode),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  bitmanip_dp #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .opSel   (opCode),
    .rs1     (rs1),
    .rs2     (rs2),
    .imm     (imm),
    .result  (result)
  );

endmodule

// File: rtl/bitmanip_unit_chk.sv
module bitmanip_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            illegal,
  input logic [XLEN-1:0] result
);

  AST_ILLEGAL_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done); // R9

  AST_RESULT_MOVES_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done); // R10

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(start) || $past(busy))); // R10

  AST_BUSY_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R11

  AST_BUSY_RISES_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R11

  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R2

endmodule

bind bitmanip_unit bitmanip_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .result  (result)
);

// File: tb/bitmanip_unit_bench.sv
module bitmanip_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opSel = '0;
  logic [31:0] rs1 = '0;
  logic [31:0] rs2 = '0;
  logic [4:0]  imm = '0;
  logic        busy;
  logic        done;
  logic        illegal;
  logic [31:0] result;

  int vecCount = 0;
  int errCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmanip_unit u_bitmanip_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .rs1(rs1), .rs2(rs2), .imm(imm),
    .busy(busy), .done(done), .illegal(illegal), .result(result)
  );

  function automatic string reqOf(input int op);
    if (op <= 2)  return "R1";
    if (op <= 5)  return "R2";
    if (op <= 8)  return "R3";
    if (op <= 12) return "R4";
    if (op <= 15) return "R5";
    if (op <= 17) return "R6";
    if (op <= 25) return "R7";
    if (op <= 28) return "R8";
    return "R9";
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] a, input int s);
    logic [31:0] r = a;
    for (int i = 0; i < s; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] im);
    int n;
    logic [31:0] r;
    int ib = int'(b[4:0]);
    int ii = int'(im);
    case (op)
      0: return a & ~b;
      1: return a | ~b;
      2: return ~(a ^ b);
      3: begin n = 0; for (int i = 31; i >= 0 && a[i] == 1'b0; i--) n++; return 32'(n); end
      4: begin n = 0; for (int i = 0; i < 32 && a[i] == 1'b0; i++) n++; return 32'(n); end
      5: begin n = 0; for (int i = 0; i < 32; i++) n += int'(a[i]); return 32'(n); end
      6: return 32'(signed'(a[7:0]));
      7: return 32'(signed'(a[15:0]));
      8: return {16'h0, a[15:0]};
      9:  return (signed'(a) < signed'(b)) ? a : b;
      10: return (a < b) ? a : b;
      11: return (signed'(a) > signed'(b)) ? a : b;
      12: return (a > b) ? a : b;
      13: return rotr(a, (32 - ib) % 32);
      14: return rotr(a, ib);
      15: return rotr(a, ii);
      16: return {a[7:0], a[15:8], a[23:16], a[31:24]};
      17: begin
        for (int k = 0; k < 4; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
        return r;
      end
      18: begin r = a; r[ib] = 1'b1; return r; end
      19: begin r = a; r[ib] = 1'b0; return r; end
      20: begin r = a; r[ib] = ~r[ib]; return r; end
      21: return {31'h0, a[ib]};
      22: begin r = a; r[ii] = 1'b1; return r; end
      23: begin r = a; r[ii] = 1'b0; return r; end
      24: begin r = a; r[ii] = ~r[ii]; return r; end
      25: return {31'h0, a[ii]};
      26: return a * 2 + b;
      27: return a * 4 + b;
      28: return a * 8 + b;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // launch one operation at a falling edge, wait for done, check everything
  task automatic runOp(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] im);
    int lat = 0;
    bit sawBusy = 0;
    bit isCnt = (op >= 3 && op <= 5);
    @(negedge clk);
    opSel = 5'(op); rs1 = a; rs2 = b; imm = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (busy) sawBusy = 1;
      @(negedge clk);
      lat++;
    end
    check(reqOf(op), $sformatf("op %0d result", op), result, model(op, a, b, im));
    check("R9", $sformatf("op %0d illegal flag", op), 32'(illegal), 32'(op >= 29));
    if (isCnt) begin
      check("R2", "count latency within 33", 32'(lat <= 33), 32'd1);
      check("R11", "busy seen during count", 32'(sawBusy), 32'd1);
    end else begin
      check("R10", "single-cycle latency", 32'(lat), 32'd1);
    end
    @(negedge clk);
    check("R10", "done width one cycle", 32'(done), 32'd0);
    check("R9", "illegal low without done", 32'(illegal), 32'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errCount++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin : stim
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R12", "reset done", 32'(done), 32'd0);
    check("R12", "reset busy", 32'(busy), 32'd0);
    check("R12", "reset illegal", 32'(illegal), 32'd0);
    check("R12", "reset result", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 count edges
    runOp(3, 32'h0, 0, 0);
    runOp(4, 32'h0, 0, 0);
    runOp(3, 32'hFFFF_FFFF, 0, 0);
    runOp(4, 32'h8000_0000, 0, 0);
    runOp(3, 32'h0000_0001, 0, 0);
    runOp(5, 32'hFFFF_FFFF, 0, 0);
    runOp(5, 32'h0, 0, 0);
    // R5 amounts with upper bits set, and zero amount
    runOp(13, 32'h8000_0001, 32'h0000_0025, 0);
    runOp(14, 32'h8000_0001, 32'hFFFF_FFE3, 0);
    runOp(15, 32'h1234_5678, 0, 5'd0);
    runOp(13, 32'h1234_5678, 32'h20, 0);
    // R4 sign boundary
    runOp(9, 32'h8000_0000, 32'h1, 0);
    runOp(10, 32'h8000_0000, 32'h1, 0);
    runOp(11, 32'hFFFF_FFFF, 32'h0, 0);
    runOp(12, 32'hFFFF_FFFF, 32'h0, 0);
    // R7 index from upper-bit-set rs2, R6, R3, R8, R1
    runOp(18, 32'h0, 32'hFFFF_FFFF, 0);
    runOp(21, 32'h8000_0000, 32'h3F, 0);
    runOp(25, 32'h8000_0000, 0, 5'd31);
    runOp(17, 32'h0100_8000, 0, 0);
    runOp(16, 32'h1122_3344, 0, 0);
    runOp(6, 32'h0000_0080, 0, 0);
    runOp(7, 32'h0000_7FFF, 0, 0);
    runOp(8, 32'hFFFF_8001, 0, 0);
    runOp(28, 32'hF000_0001, 32'h5, 0);
    runOp(2, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 0);
    // R9 illegal codes
    runOp(29, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3);
    runOp(31, 32'h1, 32'h1, 5'd1);

    // R11: start while busy is ignored
    @(negedge clk);
    opSel = 5'd3; rs1 = 32'h0001_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "busy during count", 32'(busy), 32'd1);
    opSel = 5'd0; rs1 = 32'hFFFF_FFFF; rs2 = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R11", "count kept despite extra start", result, 32'd15);
    @(negedge clk);
    check("R11", "no extra done", 32'(done), 32'd0);
    @(negedge clk);
    check("R11", "still no extra done", 32'(done), 32'd0);

    // R10: result held while idle
    held = result;
    opSel = 5'd1; rs1 = 32'h5; rs2 = 32'h5;
    repeat (5) @(negedge clk);
    check("R10", "result held while idle", result, held);

    // random mix
    for (int n = 0; n < 600; n++) begin
      runOp(int'($urandom_range(0, 31)), $urandom, $urandom, 5'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule